// File: doc/BRIEF.md
# Eight-Channel Quadrature Position Counter with Snapshot

The block tracks shaft position on eight independent quadrature encoders. Each channel has its own two-bit input pair (A and B). A synchroniser brings both inputs into the clock domain. A 4x decoder then turns every valid Gray-code step into an increment or a decrement of a signed, full-width position register.

A single latch input freezes the positions of every channel at once. All eight are copied into a shadow bank on one clock edge, so the eight readings describe the same instant. The live counters do not pause while software reads the shadow bank. Software reads it one entry at a time by driving a channel index on the read-select input. Taking the latch input low releases the snapshot, and the next rising edge of the latch input replaces it.

Top module: `enc_snap_top`

## Requirements
- R1: After reset every live counter and every shadow entry is zero, `rd_data_o` reads 0 for all channels, and `snap_valid_o` is 0.
- R2: Each of the A, B and latch inputs passes through a two-flop synchroniser. An encoder change that is set up before clock edge k is applied to the live counter at edge k+2. A latch rising edge that is set up before edge k copies the counters at edge k+2.
- R3: The decoder counts in 4x mode on the code {A,B}. The forward order 00→01→11→10→00 adds 1 per step, and the reverse order subtracts 1 per step.
- R4: When both input bits change in the same sampled cycle (an illegal jump), the counter does not change. When the inputs do not change, the counter does not change.
- R5: Counters are CNT_W-bit two's-complement values (32 bits by default, never truncated) and wrap around silently on overflow and underflow.
- R6: A rising edge on the synchronised latch copies all NUM_CH counters into the shadow bank on one clock edge. An encoder step that reaches the counters on that same edge is not included in the snapshot.
- R7: Holding the latch high takes only one snapshot. The shadow bank stays unchanged until the next rising edge of the latch.
- R8: The live counters keep counting while a snapshot is held and read. A later snapshot therefore reflects every step taken in the meantime.
- R9: `rd_data_o` combinationally shows the shadow entry of channel `rd_sel_i` (0 to NUM_CH-1).
- R10: `snap_valid_o` rises on the edge that takes a snapshot. It falls on the edge where the synchronised latch is first seen low, which is edge k+2 for a deassertion set up before edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_a_i | input | NUM_CH | Encoder A phase, one bit per channel |
| enc_b_i | input | NUM_CH | Encoder B phase, one bit per channel |
| latch_i | input | 1 | Snapshot command, acts on its rising edge |
| rd_sel_i | input | $clog2(NUM_CH) | Channel index for readout |
| rd_data_o | output | CNT_W | Shadow position of the selected channel |
| snap_valid_o | output | 1 | A snapshot is held and the latch is still high |

## Verification
The bench builds two copies of the block that share the same stimulus. The first uses the default eight channels with 32-bit counters, which covers full-width negative values. The second uses 4-bit counters, so a run of a few dozen steps wraps the counter in both directions. Both copies are checked against one bench model. Because the synchroniser and decoder delays are equal, the model can place a snapshot exactly at the step that is driven together with the latch edge.

// File: rtl/enc_snap_pkg.sv
package enc_snap_pkg;

  typedef enum logic [1:0] {
    STEP_NONE,
    STEP_UP,
    STEP_DOWN,
    STEP_BAD
  } step_e;

  // forward order of {a,b}: 00 -> 01 -> 11 -> 10 -> 00
  function automatic logic [1:0] gray_next(input logic [1:0] ab);
    case (ab)
      2'b00:   gray_next = 2'b01;
      2'b01:   gray_next = 2'b11;
      2'b11:   gray_next = 2'b10;
      default: gray_next = 2'b00;
    endcase
  endfunction

  function automatic step_e classify(input logic [1:0] prev, input logic [1:0] cur);
    if (prev == cur)                  classify = STEP_NONE;
    else if ((prev ^ cur) == 2'b11)   classify = STEP_BAD;
    else if (gray_next(prev) == cur)  classify = STEP_UP;
    else                              classify = STEP_DOWN;
  endfunction

endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/quad_counter.sv
module quad_counter
  import enc_snap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       ab_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [1:0]       ab_q;
  logic [CNT_W-1:0] cnt_q;
  step_e            step;

  assign step = classify(ab_q, ab_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ab_q  <= 2'b00;
      cnt_q <= '0;
    end else begin
      ab_q <= ab_i;
      case (step)
        STEP_UP:   cnt_q <= cnt_q + ONE;  // wraps silently
        STEP_DOWN: cnt_q <= cnt_q - ONE;
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;

  p_step_unit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE));

  p_bad_jump_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ab_q ^ ab_i) == 2'b11) |=> $stable(cnt_q));

  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_q == ab_i) |=> $stable(cnt_q));

endmodule

// File: rtl/snap_bank.sv
module snap_bank #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          latch_s_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all_i,
  input  logic [SEL_W-1:0]              rd_sel_i,
  output logic [CNT_W-1:0]              rd_data_o,
  output logic                          snap_valid_o
);

  logic                         latch_q;
  logic                         take;
  logic                         valid_q;
  logic [NUM_CH-1:0][CNT_W-1:0] shadow_q;

  assign take = latch_s_i && !latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q  <= 1'b0;
      valid_q  <= 1'b0;
      shadow_q <= '0;
    end else begin
      latch_q <= latch_s_i;
      if (take) begin
        shadow_q <= cnt_all_i;  // all channels on one edge
        valid_q  <= 1'b1;
      end else if (!latch_s_i) begin
        valid_q  <= 1'b0;
      end
    end
  end

  // R9: combinational channel select
  assign rd_data_o    = shadow_q[rd_sel_i];
  assign snap_valid_o = valid_q;

  p_snap_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_s_i && !latch_q) |=> (shadow_q == $past(cnt_all_i)));

  p_shadow_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(latch_s_i && !latch_q) |=> $stable(shadow_q));

  p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_s_i |=> !valid_q);

  p_valid_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(latch_s_i));

endmodule

// File: rtl/enc_snap_top.sv
module enc_snap_top #(
  parameter int NUM_CH      = 8,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_CH),
  localparam int SYNC_W     = 2 * NUM_CH + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] enc_a_i,
  input  logic [NUM_CH-1:0] enc_b_i,
  input  logic              latch_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              snap_valid_o
);

  logic [SYNC_W-1:0]            sync_out;
  logic [NUM_CH-1:0]            a_s, b_s;
  logic                         latch_s;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;

  // R2: one synchroniser chain for all inputs, equal delay on every path
  enc_sync #(
    .W      (SYNC_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({latch_i, enc_b_i, enc_a_i}),
    .q_o    (sync_out)
  );

  assign a_s     = sync_out[NUM_CH-1:0];
  assign b_s     = sync_out[2*NUM_CH-1:NUM_CH];
  assign latch_s = sync_out[SYNC_W-1];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    quad_counter #(
      .CNT_W (CNT_W)
    ) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ab_i   ({a_s[ch], b_s[ch]}),
      .cnt_o  (cnt_all[ch])
    );
  end

  snap_bank #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
  ) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .latch_s_i    (latch_s),
    .cnt_all_i    (cnt_all),
    .rd_sel_i     (rd_sel_i),
    .rd_data_o    (rd_data_o),
    .snap_valid_o (snap_valid_o)
  );

endmodule

// File: tb/enc_snap_top_tb_top.sv
module enc_snap_top_tb_top;

  localparam int NCH = 8;
  localparam int NW  = 4;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NCH-1:0]  a, b;
  logic            latch;
  logic [2:0]      sel;
  logic [31:0]     rd;
  logic [NW-1:0]   rdw;
  logic            val, valw;

  int         mdl  [NCH];
  int         shad [NCH];
  logic [1:0] ab   [NCH];
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;
  int unsigned seed_v;

  always #4 clk = ~clk;

  enc_snap_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .enc_a_i(a), .enc_b_i(b), .latch_i(latch),
    .rd_sel_i(sel), .rd_data_o(rd), .snap_valid_o(val));

  enc_snap_top #(.CNT_W(NW)) dut_w_i (
    .clk_i(clk), .rst_ni(rst_ni), .enc_a_i(a), .enc_b_i(b), .latch_i(latch),
    .rd_sel_i(sel), .rd_data_o(rdw), .snap_valid_o(valw));

  function automatic logic [1:0] fwd(input logic [1:0] x);
    case (x)
      2'b00:   return 2'b01;
      2'b01:   return 2'b11;
      2'b11:   return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] rev(input logic [1:0] x);
    case (x)
      2'b00:   return 2'b10;
      2'b10:   return 2'b11;
      2'b11:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // mode: 0 random, 1 forward, 2 reverse, 3 hold, 4 illegal jump
  task automatic drive(input int mode, input bit lat);
    @(negedge clk);
    if (lat && !latch) for (int i = 0; i < NCH; i++) shad[i] = mdl[i];
    latch = lat;
    for (int i = 0; i < NCH; i++) begin
      int m;
      m = mode;
      if (mode == 0) begin
        int r;
        r = int'($urandom % 8);
        m = (r == 0) ? 3 : (r <= 3) ? 1 : (r <= 6) ? 2 : 4;
      end
      case (m)
        1: begin ab[i] = fwd(ab[i]); mdl[i] = mdl[i] + 1; end
        2: begin ab[i] = rev(ab[i]); mdl[i] = mdl[i] - 1; end
        4: ab[i] = ~ab[i];
        default: ;
      endcase
      a[i] = ab[i][1];
      b[i] = ab[i][0];
    end
  endtask

  task automatic settle();
    repeat (3) drive(0, latch);
  endtask

  // counters keep moving between reads (R8)
  task automatic read_all(input string req);
    for (int ch = 0; ch < NCH; ch++) begin
      sel = 3'(ch);
      #1;
      chk(req, rd, shad[ch]);
      chk(req, 32'(rdw), 32'(shad[ch][NW-1:0]));
      drive(0, latch);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    seed_v = $urandom(32'd1234);
    a = '0; b = '0; latch = 1'b0; sel = '0;
    for (int i = 0; i < NCH; i++) begin ab[i] = 2'b00; mdl[i] = 0; shad[i] = 0; end
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1", 32'(val), 32'd0);
    chk("R1", 32'(valw), 32'd0);
    for (int ch = 0; ch < NCH; ch++) begin
      sel = 3'(ch);
      #1;
      chk("R1", rd, 32'd0);
    end

    // R3 forward counting, snapshot
    repeat (5) drive(1, 0);
    drive(3, 1);
    settle();
    read_all("R3");
    chk("R10", 32'(val), 32'd1);

    // R10 release timing
    drive(3, 0);
    drive(3, 0);
    drive(3, 0);
    chk("R10", 32'(val), 32'd1);
    drive(3, 0);
    chk("R10", 32'(val), 32'd0);

    // R4 illegal jumps ignored, then reverse; R6 latch on same cycle as a step
    repeat (3) drive(4, 0);
    repeat (8) drive(2, 0);
    repeat (2) drive(3, 0);
    drive(1, 1);
    settle();
    read_all("R4");
    read_all("R6");

    // R2 step one cycle before latch is included
    drive(3, 0);
    drive(1, 0);
    drive(3, 1);
    settle();
    read_all("R2");

    // R7 holding latch takes one snapshot
    drive(3, 0);
    drive(1, 0);
    drive(3, 1);
    repeat (4) drive(1, 1);
    settle();
    read_all("R7");

    // R8 new snapshot reflects counting done meanwhile
    drive(3, 0);
    drive(3, 1);
    settle();
    read_all("R8");

    // R5 wrap: narrow copy wraps upward, wide copy goes negative
    drive(3, 0);
    repeat (20) drive(1, 0);
    drive(3, 1);
    settle();
    read_all("R5");
    drive(3, 0);
    repeat (70) drive(2, 0);
    drive(3, 1);
    settle();
    read_all("R5");

    // R9 random rounds
    for (int r = 0; r < 30; r++) begin
      drive(0, 0);
      repeat (1 + int'($urandom % 20)) drive(0, 0);
      drive(0, 1);
      settle();
      chk("R10", 32'(val), 32'd1);
      read_all("R9");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule